// File: doc/BRIEF.md
# Availability-Qualified Priority Clock Source Selector

This block picks the system clock source for a chip from three candidates: a throughput clock, a low-power clock and an idle-mode clock. Any of several cores may ask for the throughput or the low-power clock at any time. A readiness vector from the resource sequencer says which of the two higher sources is currently running. The block grants the fastest source that is both wanted and ready. When a wanted source is not ready, it drops to the next slower source. The idle-mode clock is the floor. It never needs a request and is always assumed present.

The result is a registered one-hot select word and a one-cycle change strobe. A downstream glitch-free clock multiplexer consumes both. A global enable input gates the whole decision. While the enable is low, the block holds the idle-mode clock.

Internally the choice is a three-state machine: IDLE, LOWPWR and THRU. Each cycle it moves to the state that the request and readiness inputs call for.

The named transitions are:
- IDLE_TO_LOWPWR
- IDLE_TO_THRU
- LOWPWR_TO_THRU
- THRU_TO_LOWPWR (fallback)
- THRU_TO_IDLE (fallback)
- LOWPWR_TO_IDLE (fallback)
- HOLD, which stays in the current state.

Top module: `clk_src_selector`

## Requirements
- R1: While reset is asserted, `clk_sel` is 3'b001 (idle-mode) and `sel_changed` is 0.
- R2: When any core raises its throughput request, bit 1 of `src_ready` (throughput ready) is 1 and `sel_enable` is 1, `clk_sel` becomes 3'b100 at the next clock edge.
- R3: When one core requests throughput and another requests low-power while throughput is not ready and low-power is ready (`src_ready` bit 0), `clk_sel` becomes 3'b010.
- R4: When a throughput request is held and throughput readiness drops, the select moves to low-power (3'b010) if low-power is ready, even if no core requests low-power. If low-power is also not ready, it moves to idle-mode (3'b001).
- R5: When low-power is requested but not ready, and no throughput request is active, the select is idle-mode (3'b001).
- R6: With no request from any core, the select is idle-mode (3'b001), whatever the readiness inputs are.
- R7: While `sel_enable` is 0, the select is idle-mode (3'b001) at the next edge, regardless of requests or readiness.
- R8: `sel_changed` is 1 for exactly the cycle in which `clk_sel` differs from its value in the previous cycle, and 0 otherwise.
- R9: `clk_sel` is always one-hot (bit 2 throughput, bit 1 low-power, bit 0 idle-mode).
- R10: Every core's request line counts on its own; a request from any single core position is sufficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_enable | input | 1 | Decision enable; low forces idle-mode |
| req_thru | input | NUM_CORES | Per-core throughput clock request |
| req_lowpwr | input | NUM_CORES | Per-core low-power clock request |
| src_ready | input | 2 | Source readiness: bit 1 throughput, bit 0 low-power |
| clk_sel | output | 3 | One-hot select: bit 2 throughput, bit 1 low-power, bit 0 idle |
| sel_changed | output | 1 | One-cycle pulse when the select changes |

## Verification
The bench builds the block with its default of six cores. It walks a lone throughput request across every core position, which reaches each leg of the per-core reduction tree. Readiness is toggled under held requests to drive every fallback transition of the state machine. The change strobe is predicted on every step from the bench's own expected select history.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    // Number of selectable clock sources and their one-hot bit positions.
    localparam int SRC_N   = 3;
    localparam int IDX_IDL = 0;
    localparam int IDX_LP  = 1;
    localparam int IDX_TP  = 2;

    // Readiness vector bit positions.
    localparam int RDY_LP  = 0;
    localparam int RDY_TP  = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOWPWR = 2'd1,
        ST_THRU   = 2'd2
    } clk_state_t;

    typedef enum logic [2:0] {
        TR_HOLD,
        TR_IDLE_TO_LOWPWR,
        TR_IDLE_TO_THRU,
        TR_LOWPWR_TO_THRU,
        TR_LOWPWR_TO_IDLE,
        TR_THRU_TO_LOWPWR,
        TR_THRU_TO_IDLE
    } clk_trans_t;

    function automatic logic [SRC_N-1:0] state_onehot(clk_state_t s);
        logic [SRC_N-1:0] v;
        v = '0;
        unique case (s)
            ST_IDLE:   v[IDX_IDL] = 1'b1;
            ST_LOWPWR: v[IDX_LP]  = 1'b1;
            ST_THRU:   v[IDX_TP]  = 1'b1;
            default:   v[IDX_IDL] = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/clksel_req_merge.sv
module clksel_req_merge #(
    parameter int NUM_CORES = 6
) (
    input  logic [NUM_CORES-1:0] req_thru,
    input  logic [NUM_CORES-1:0] req_lowpwr,
    output logic                 any_thru,
    output logic                 any_lowpwr
);
    localparam int CHAIN_W = NUM_CORES + 1;

    logic [CHAIN_W-1:0] tp_chain;
    logic [CHAIN_W-1:0] lp_chain;

    assign tp_chain[0] = 1'b0;
    assign lp_chain[0] = 1'b0;

    // One OR stage per core; each core contributes independently.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign tp_chain[c+1] = tp_chain[c] | req_thru[c];
        assign lp_chain[c+1] = lp_chain[c] | req_lowpwr[c];
    end

    assign any_thru   = tp_chain[NUM_CORES];
    assign any_lowpwr = lp_chain[NUM_CORES];
endmodule

// File: rtl/clksel_target.sv
module clksel_target
    import clksel_pkg::*;
(
    input  logic       sel_enable,
    input  logic       any_thru,
    input  logic       any_lowpwr,
    input  logic [1:0] src_ready,
    output clk_state_t target
);
    logic want_tp;
    logic want_lp;

    // A held throughput request may fall back to low-power without
    // any core asking for low-power.
    assign want_tp = any_thru & src_ready[RDY_TP];
    assign want_lp = (any_thru | any_lowpwr) & src_ready[RDY_LP];

    always_comb begin
        if (!sel_enable)  target = ST_IDLE;
        else if (want_tp) target = ST_THRU;
        else if (want_lp) target = ST_LOWPWR;
        else              target = ST_IDLE;
    end
endmodule

// File: rtl/clk_src_selector.sv
module clk_src_selector
    import clksel_pkg::*;
#(
    parameter int NUM_CORES = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_enable,
    input  logic [NUM_CORES-1:0] req_thru,
    input  logic [NUM_CORES-1:0] req_lowpwr,
    input  logic [1:0]           src_ready,
    output logic [2:0]           clk_sel,
    output logic                 sel_changed
);
    logic       any_thru;
    logic       any_lowpwr;
    clk_state_t target;
    clk_state_t state_q;
    clk_state_t state_d;
    clk_trans_t trans;
    logic       chg_q;

    clksel_req_merge #(.NUM_CORES(NUM_CORES)) u_merge (
        .req_thru   (req_thru),
        .req_lowpwr (req_lowpwr),
        .any_thru   (any_thru),
        .any_lowpwr (any_lowpwr)
    );

    clksel_target u_target (
        .sel_enable (sel_enable),
        .any_thru   (any_thru),
        .any_lowpwr (any_lowpwr),
        .src_ready  (src_ready),
        .target     (target)
    );

    // Transition decode: each state names the move it takes.
    always_comb begin
        trans = TR_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                if (target == ST_THRU)        trans = TR_IDLE_TO_THRU;
                else if (target == ST_LOWPWR) trans = TR_IDLE_TO_LOWPWR;
            end
            ST_LOWPWR: begin
                if (target == ST_THRU)        trans = TR_LOWPWR_TO_THRU;
                else if (target == ST_IDLE)   trans = TR_LOWPWR_TO_IDLE;
            end
            ST_THRU: begin
                if (target == ST_LOWPWR)      trans = TR_THRU_TO_LOWPWR;
                else if (target == ST_IDLE)   trans = TR_THRU_TO_IDLE;
            end
            default: trans = TR_THRU_TO_IDLE;
        endcase
    end

    always_comb begin
        unique case (trans)
            TR_IDLE_TO_LOWPWR,
            TR_THRU_TO_LOWPWR:  state_d = ST_LOWPWR;
            TR_IDLE_TO_THRU,
            TR_LOWPWR_TO_THRU:  state_d = ST_THRU;
            TR_LOWPWR_TO_IDLE,
            TR_THRU_TO_IDLE:    state_d = ST_IDLE;
            TR_HOLD:            state_d = state_q;
            default:            state_d = ST_IDLE;
        endcase
    end

    // State register and change strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            chg_q   <= (trans != TR_HOLD);
        end
    end

    // Outputs.
    always_comb begin
        clk_sel     = state_onehot(state_q);
        sel_changed = chg_q;
    end
endmodule

// File: rtl/clk_src_selector_chk.sv
module clk_src_selector_chk #(
    parameter int NUM_CORES = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sel_enable,
    input logic [NUM_CORES-1:0] req_thru,
    input logic [NUM_CORES-1:0] req_lowpwr,
    input logic [1:0]           src_ready,
    input logic [2:0]           clk_sel,
    input logic                 sel_changed
);
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(clk_sel));

    p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_changed == (clk_sel != $past(clk_sel)));

    p_gate_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_enable |=> clk_sel == 3'b001);

    p_noreq_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_thru == '0 && req_lowpwr == '0) |=> clk_sel == 3'b001);

    p_thru_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_enable && req_thru != '0 && src_ready[1]) |=> clk_sel == 3'b100);

    p_fallback_lp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_enable && req_thru != '0 && !src_ready[1] && src_ready[0])
            |=> clk_sel == 3'b010);
endmodule

bind clk_src_selector clk_src_selector_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_enable  (sel_enable),
    .req_thru    (req_thru),
    .req_lowpwr  (req_lowpwr),
    .src_ready   (src_ready),
    .clk_sel     (clk_sel),
    .sel_changed (sel_changed)
);

// File: tb/clk_src_selector_test.sv
`timescale 1ns/1ps
module clk_src_selector_test;
    localparam int NC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_enable = 1'b0;
    logic [NC-1:0] req_thru = '0;
    logic [NC-1:0] req_lowpwr = '0;
    logic [1:0]    src_ready = 2'b00;
    logic [2:0]    clk_sel;
    logic          sel_changed;

    int checks = 0;
    int errors = 0;
    logic [2:0] last_exp = 3'b001;

    always #2 clk = ~clk;

    clk_src_selector #(.NUM_CORES(NC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_enable  (sel_enable),
        .req_thru    (req_thru),
        .req_lowpwr  (req_lowpwr),
        .src_ready   (src_ready),
        .clk_sel     (clk_sel),
        .sel_changed (sel_changed)
    );

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, got, exp);
        end
    endtask

    // Advance one edge, then check select and strobe (R8).
    task automatic step_expect(input string tag, input logic [2:0] exp);
        @(posedge clk); #1;
        chk(tag, clk_sel, exp);
        chk("R8 strobe", {2'b00, sel_changed}, {2'b00, exp != last_exp});
        last_exp = exp;
    endtask

    task automatic clear_inputs();
        req_thru = '0; req_lowpwr = '0; src_ready = 2'b11; sel_enable = 1'b1;
    endtask

    task automatic t_reset();
        @(posedge clk); #1;
        chk("R1 sel in reset", clk_sel, 3'b001);
        chk("R1 strobe in reset", {2'b00, sel_changed}, 3'b000);
        rst_n = 1'b1;
        last_exp = 3'b001;
    endtask

    task automatic t_each_core();
        for (int c = 0; c < NC; c++) begin
            clear_inputs();
            req_thru[c] = 1'b1;
            step_expect($sformatf("R2 R10 core %0d", c), 3'b100);
            clear_inputs();
            step_expect("R6 release", 3'b001);
        end
    endtask

    task automatic t_tp_vs_lp();
        clear_inputs();
        req_lowpwr[0] = 1'b1; req_thru[3] = 1'b1; src_ready = 2'b01;
        step_expect("R3 thru not ready", 3'b010);
        src_ready = 2'b11;
        step_expect("R3 thru ready", 3'b100);
        step_expect("R8 hold", 3'b100);
    endtask

    task automatic t_tp_drop();
        clear_inputs();
        req_thru[5] = 1'b1;
        step_expect("R4 grant", 3'b100);
        src_ready = 2'b01;
        step_expect("R4 fall to lowpwr", 3'b010);
        src_ready = 2'b00;
        step_expect("R4 fall to idle", 3'b001);
        src_ready = 2'b10;
        step_expect("R4 recover", 3'b100);
    endtask

    task automatic t_lp_unready();
        clear_inputs();
        req_lowpwr[2] = 1'b1; src_ready = 2'b10;
        step_expect("R5 lowpwr not ready", 3'b001);
        src_ready = 2'b01;
        step_expect("R5 lowpwr ready", 3'b010);
    endtask

    task automatic t_none();
        clear_inputs();
        step_expect("R6 no request", 3'b001);
        src_ready = 2'b00;
        step_expect("R6 no request none ready", 3'b001);
    endtask

    task automatic t_gate();
        clear_inputs();
        req_thru = '1; req_lowpwr = '1;
        step_expect("R7 enabled", 3'b100);
        sel_enable = 1'b0;
        step_expect("R7 disabled", 3'b001);
        step_expect("R7 still disabled", 3'b001);
        sel_enable = 1'b1;
        step_expect("R7 reenabled", 3'b100);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_each_core();
        t_tp_vs_lp();
        t_tp_drop();
        t_lp_unready();
        t_none();
        t_gate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule